// File: doc/BRIEF.md
# Dual 4-bit binary up-counter

Two separate 4-bit binary up-counters share one module and one free-running system clock. Each counter has three asynchronous pins: a count clock, a count enable and a clear. The clock and enable pins can trade roles. A counter steps by one when its clock pin rises while its enable pin is high. It also steps by one when its enable pin falls while its clock pin is low. A high clear pin forces the counter to zero. All four bits of a counter change in the same system-clock cycle, and the count wraps from 15 back to 0.

Every pin passes through a synchroniser on the system clock. Edges are found by comparing each synchronised level with the level held one cycle earlier. A build-time option chains the two counters in ripple fashion. In that mode, counter B takes its enable from counter A's top bit and its clock is held low internally. Counter B then advances each time A's top bit falls.

After the system reset, the pins are taken to be low. Pins should be low when the system reset is released.

Top module: `dual_upcount`

## Requirements
- R1: While `rst_n` is low, and after its release with all pins low, `a_q` and `b_q` read 0.
- R2: A rising count-clock pin, with the enable pin high before the edge, adds one to the count. The new value appears after the third rising `clk` edge following the pin change and not after the second.
- R3: A falling enable pin, with the count-clock pin low before the edge, adds one to the count.
- R4: None of these change the count: a falling clock pin; a rising enable pin; a rising clock pin with enable low; a falling enable pin with the clock pin high.
- R5: While a clear pin is high, its counter reads 0 and accepts no increment. Clear takes priority over an edge seen in the same cycle.
- R6: A counter at 15 that receives a step reads 0.
- R7: Pin activity on one counter never changes the other counter when `CASCADE` = 0.
- R8: A rising clock pin and a falling enable pin that change together add exactly one to the count.
- R9: With `CASCADE` = 1, counter B's clock and enable pins are ignored. B adds one each time bit 3 of `a_q` goes from 1 to 0, whether A wrapped from 15 or was cleared from 8 or more.
- R10: From one system cycle to the next, a count either stays the same, goes up by one modulo 16, or becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low system reset |
| a_clk_pin | input | 1 | Counter A count clock, asynchronous |
| a_en_pin | input | 1 | Counter A count enable, asynchronous |
| a_clr_pin | input | 1 | Counter A clear, active high, asynchronous |
| b_clk_pin | input | 1 | Counter B count clock (ignored when cascaded) |
| b_en_pin | input | 1 | Counter B count enable (ignored when cascaded) |
| b_clr_pin | input | 1 | Counter B clear, active high, asynchronous |
| a_q | output | 4 | Counter A value |
| b_q | output | 4 | Counter B value |

## Verification
On every cycle, the assertions check the following for each counter: the value moves only by +1 or to 0, it holds still when no step is decoded, clear holds it at zero, and a step at 15 wraps to 0. In the cascaded build, they also check that B moves only one cycle after A's top bit falls. Only the bench scenarios can show that particular pin sequences produce or withhold a step: the role swap between clock and enable, the transitions that must be ignored, a simultaneous clock rise and enable fall, and the three-cycle input latency. The same holds for independence between the counters and for B ignoring its own pins when chained.

// File: rtl/dup_pkg.sv
package dup_pkg;
  localparam int unsigned CH_A = 0;
  localparam int unsigned CH_B = 1;
  localparam int unsigned NCH  = 2;

  // Trigger rule: a clock rise qualified by the enable level held before it,
  // or an enable fall qualified by the clock level held before it.
  function automatic logic trig_rule(input logic clk_rise, input logic en_fall,
                                     input logic en_before, input logic clk_before);
    return (clk_rise & en_before) | (en_fall & ~clk_before);
  endfunction
endpackage

// File: rtl/dup_sync.sv
module dup_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/dup_trigger.sv
module dup_trigger
  import dup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_clk,
  input  logic lvl_en,
  output logic clk_rise,
  output logic en_fall,
  output logic step
);
  logic prev_clk, prev_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_clk <= 1'b0;
      prev_en  <= 1'b0;
    end else begin
      prev_clk <= lvl_clk;
      prev_en  <= lvl_en;
    end
  end

  assign clk_rise = lvl_clk & ~prev_clk;
  assign en_fall  = ~lvl_en & prev_en;
  assign step     = trig_rule(clk_rise, en_fall, prev_en, prev_clk);

  // R8
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_rise && en_fall) |-> (step == (prev_en || !prev_clk)));
endmodule

// File: rtl/dup_counter.sv
module dup_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (step) q <= bump(q);
  end

  // R5
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q == '1 && step && !clr) |=> (q == '0));
  // R4
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(q));
  // R10
  move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q != $past(q)) |-> (q == $past(q) + W'(1) || q == '0));
endmodule

// File: rtl/dual_upcount.sv
module dual_upcount
  import dup_pkg::*;
#(
  parameter int unsigned W           = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          CASCADE     = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_clk_pin,
  input  logic         a_en_pin,
  input  logic         a_clr_pin,
  input  logic         b_clk_pin,
  input  logic         b_en_pin,
  input  logic         b_clr_pin,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q
);
  localparam int unsigned PINS_PER_CH = 3;
  localparam int unsigned NPINS       = PINS_PER_CH * NCH;

  logic [NPINS-1:0] pins_raw, pins_s;
  logic [NCH-1:0]   ch_clk, ch_en, ch_clr, ch_step, ch_rise, ch_fall;
  logic [W-1:0]     ch_q [NCH];
  logic             a_top;

  assign pins_raw = {b_clr_pin, b_en_pin, b_clk_pin, a_clr_pin, a_en_pin, a_clk_pin};

  dup_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pins_raw), .sync_out(pins_s)
  );

  assign a_top = ch_q[CH_A][W-1];

  // Channel A always uses its own pins; B may be chained to A's top bit.
  assign ch_clk[CH_A] = pins_s[0];
  assign ch_en[CH_A]  = pins_s[1];
  assign ch_clr[CH_A] = pins_s[2];
  assign ch_clk[CH_B] = CASCADE ? 1'b0  : pins_s[3];
  assign ch_en[CH_B]  = CASCADE ? a_top : pins_s[4];
  assign ch_clr[CH_B] = pins_s[5];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dup_trigger u_trig (
      .clk(clk), .rst_n(rst_n), .lvl_clk(ch_clk[c]), .lvl_en(ch_en[c]),
      .clk_rise(ch_rise[c]), .en_fall(ch_fall[c]), .step(ch_step[c])
    );
    dup_counter #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(ch_clr[c]), .step(ch_step[c]), .q(ch_q[c])
    );
  end

  assign a_q = ch_q[CH_A];
  assign b_q = ch_q[CH_B];

  if (CASCADE) begin : g_casc_chk
    // R9
    casc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_q[CH_B] != $past(ch_q[CH_B]) && !$past(ch_clr[CH_B]))
        |-> ($past(a_top, 2) && !$past(a_top)));
  end
endmodule

// File: tb/dual_upcount_bench.sv
`timescale 1ns/1ps
module dual_upcount_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic a_clk_pin = 0, a_en_pin = 0, a_clr_pin = 0;
  logic b_clk_pin = 0, b_en_pin = 0, b_clr_pin = 0;
  logic [3:0] a_q, b_q;

  logic c_a_clk = 0, c_a_en = 0, c_a_clr = 0;
  logic c_b_clk = 0, c_b_en = 0, c_b_clr = 0;
  logic [3:0] c_a_q, c_b_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  dual_upcount u_dual_upcount (
    .clk(clk), .rst_n(rst_n),
    .a_clk_pin(a_clk_pin), .a_en_pin(a_en_pin), .a_clr_pin(a_clr_pin),
    .b_clk_pin(b_clk_pin), .b_en_pin(b_en_pin), .b_clr_pin(b_clr_pin),
    .a_q(a_q), .b_q(b_q)
  );

  dual_upcount #(.CASCADE(1'b1)) u_dual_upcount_casc (
    .clk(clk), .rst_n(rst_n),
    .a_clk_pin(c_a_clk), .a_en_pin(c_a_en), .a_clr_pin(c_a_clr),
    .b_clk_pin(c_b_clk), .b_en_pin(c_b_en), .b_clr_pin(c_b_clr),
    .a_q(c_a_q), .b_q(c_b_q)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Let a pin change settle: synchroniser plus edge register plus counter.
  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic a_clock_pulse();
    a_clk_pin = 1; settle();
    a_clk_pin = 0; settle();
  endtask

  task automatic c_a_pulse();
    c_a_clk = 1; settle();
    c_a_clk = 0; settle();
  endtask

  task automatic t_reset();
    check("R1 a after reset", a_q, 4'd0);
    check("R1 b after reset", b_q, 4'd0);
    check("R1 cascaded b after reset", c_b_q, 4'd0);
  endtask

  task automatic t_clock_count();
    a_en_pin = 1; settle();
    a_clk_pin = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 not yet after two edges", a_q, 4'd0);
    @(posedge clk); @(negedge clk);
    check("R2 visible after third edge", a_q, 4'd1);
    a_clk_pin = 0; settle();
    check("R4 falling clock ignored", a_q, 4'd1);
    a_clock_pulse(); a_clock_pulse();
    check("R2 three clock rises", a_q, 4'd3);
  endtask

  task automatic t_enable_count();
    a_en_pin = 0; settle();
    check("R3 falling enable counts", a_q, 4'd4);
    a_en_pin = 1; settle();
    check("R4 rising enable ignored", a_q, 4'd4);
    a_en_pin = 0; settle();
    check("R3 second enable fall", a_q, 4'd5);
  endtask

  task automatic t_ignored();
    a_clk_pin = 1; settle();
    check("R4 clock rise with enable low", a_q, 4'd5);
    a_en_pin = 1; settle();
    a_en_pin = 0; settle();
    check("R4 enable fall with clock high", a_q, 4'd5);
    a_clk_pin = 0; settle();
    check("R4 clock fall", a_q, 4'd5);
  endtask

  task automatic t_indep();
    check("R7 b untouched by a activity", b_q, 4'd0);
    b_en_pin = 1; settle();
    b_clk_pin = 1; settle(); b_clk_pin = 0; settle();
    b_en_pin = 0; settle();
    check("R7 b counted own edges", b_q, 4'd2);
    check("R7 a untouched by b activity", a_q, 4'd5);
  endtask

  task automatic t_simul();
    a_en_pin = 1; settle();
    a_clk_pin = 1; a_en_pin = 0; settle();
    check("R8 simultaneous edges add one", a_q, 4'd6);
    a_clk_pin = 0; settle();
  endtask

  task automatic t_wrap();
    a_en_pin = 1; settle();
    for (int i = 0; i < 9; i++) a_clock_pulse();
    check("R6 reached fifteen", a_q, 4'd15);
    a_clock_pulse();
    check("R6 wraps to zero", a_q, 4'd0);
  endtask

  task automatic t_clear();
    a_clock_pulse(); a_clock_pulse();
    check("R5 preset value", a_q, 4'd2);
    a_clr_pin = 1; settle();
    check("R5 clear forces zero", a_q, 4'd0);
    a_clock_pulse();
    check("R5 no count while clear high", a_q, 4'd0);
    a_clr_pin = 0; settle();
    check("R5 stays zero after release", a_q, 4'd0);
    a_clock_pulse();
    check("R5 counts again after release", a_q, 4'd1);
    check("R7 b unaffected by a clear", b_q, 4'd2);
  endtask

  task automatic t_cascade();
    c_a_en = 1; settle();
    for (int i = 0; i < 15; i++) c_a_pulse();
    check("R9 b idle before a wraps", c_b_q, 4'd0);
    c_a_pulse();
    check("R9 a wrapped", c_a_q, 4'd0);
    check("R9 b advances on a wrap", c_b_q, 4'd1);
    c_b_en = 1; settle();
    c_b_clk = 1; settle(); c_b_clk = 0; settle();
    c_b_en = 0; settle();
    check("R9 b own pins ignored", c_b_q, 4'd1);
    for (int i = 0; i < 9; i++) c_a_pulse();
    check("R9 a at nine", c_a_q, 4'd9);
    c_a_clr = 1; settle();
    check("R9 b advances when a clear drops top bit", c_b_q, 4'd2);
    c_a_clr = 0; settle();
    c_b_clr = 1; settle();
    check("R5 cascaded b clears", c_b_q, 4'd0);
    c_b_clr = 0; settle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    settle();
    t_reset();
    t_clock_count();
    t_enable_count();
    t_ignored();
    t_indep();
    t_simul();
    t_wrap();
    t_clear();
    t_cascade();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule